// File: doc/BRIEF.md
# Carry-Free Signed-Digit Word Adder

This block adds two words written in binary signed digits, where every digit takes the value -1, 0 or +1. Each digit travels on two wires of equal weight, an up rail and a down rail, and the digit's value is the up bit minus the down bit. The adder is purely combinational. Its delay does not grow with the word width, because no carry travels more than one position.

Every position looks at its own pair of operand digits and at the pair one position below. From these it chooses an outgoing transfer and a local remainder, and it never waits for the transfer coming up from below. The result digit at a position is that position's remainder plus the transfer arriving from beneath, and the choice rule keeps this sum within one digit. A signed carry-in digit plays the part of the lower neighbour of the bottom position. The transfer out of the top position becomes one extra result digit. Negating an operand before it enters costs nothing: the caller swaps its two rails.

Top module: `bsd_cf_adder`

## Requirements
- R1: The value of the result word equals the value of operand A, plus the value of operand B, plus the carry-in digit. A word's value is the sum of digit i times 2^i, and a digit's value is its up bit minus its down bit.
- R2: On the operand and carry-in rails, up/down = 1/0 means +1, 0/1 means -1, and both 0/0 and 1/1 mean 0. Swapping 0/0 for 1/1 on any input digit leaves the result rails unchanged.
- R3: A result digit is never driven as 1/1. A zero result digit is always 0/0, so +1 is 1/0 and -1 is 0/1.
- R4: Result digits 0 to k-1 do not depend on operand digits at positions k and above.
- R5: Position i takes s = x_i + y_i. If s is +2, the transfer is +1 and the remainder 0. If s is -2, the transfer is -1 and the remainder 0. If s is 0, both are 0. If s is +1, the transfer is +1 and the remainder -1 when both digits at i-1 are non-negative; otherwise the transfer is 0 and the remainder +1. If s is -1, the transfer is 0 and the remainder -1 when both digits at i-1 are non-negative; otherwise the transfer is -1 and the remainder +1. Result digit i is the remainder at i plus the transfer from i-1, and this sum always stays within {-1, 0, +1}.
- R6: The carry-in digit is the transfer that arrives at position 0, and it serves as the lower digit pair (carry-in, 0) when position 0 makes its choice. Result digit DIGITS equals the transfer out of position DIGITS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_pos | input | DIGITS | Up rails of operand A |
| a_neg | input | DIGITS | Down rails of operand A |
| b_pos | input | DIGITS | Up rails of operand B |
| b_neg | input | DIGITS | Down rails of operand B |
| cin_pos | input | 1 | Up rail of the carry-in digit |
| cin_neg | input | 1 | Down rail of the carry-in digit |
| sum_pos | output | DIGITS+1 | Up rails of the result |
| sum_neg | output | DIGITS+1 | Down rails of the result |

## Verification
The assertions check the word value, the canonical form of the outputs, the range of each result digit and the sign of each transfer. They apply only when every input rail is 0 or 1; while any input is unknown, the checker stays silent. The stimulus drives all inputs to zero before the first clock edge. After that it only ever writes defined bit patterns, including the redundant 1/1 form of zero, so every cycle lies inside the assumed input space.

// File: rtl/bsd_sd_pkg.sv
package bsd_sd_pkg;

  // Transfer/remainder pair chosen by one digit position.
  typedef struct packed {
    logic signed [1:0] c;
    logic signed [1:0] s;
  } xfer_t;

  // Value of a digit carried on two equal-weight rails.
  function automatic logic signed [1:0] dig_value(input logic up, input logic dn);
    logic signed [1:0] u;
    logic signed [1:0] d;
    u = $signed({1'b0, up});
    d = $signed({1'b0, dn});
    return u - d;
  endfunction

  // Canonical rails {up, dn} for a value in -1..+1; anything else maps to 00.
  function automatic logic [1:0] dig_encode(input logic signed [2:0] v);
    logic [1:0] r;
    case (v)
      3'sd1:   r = 2'b10;
      -3'sd1:  r = 2'b01;
      default: r = 2'b00;
    endcase
    return r;
  endfunction

  // Digit is non-negative unless only its down rail is set.
  function automatic logic dig_nonneg(input logic up, input logic dn);
    return ~(dn & ~up);
  endfunction

  // Choice of transfer and remainder from the local pair sum and the lower context.
  function automatic xfer_t xfer_rule(input logic signed [2:0] pair_sum, input logic low_nonneg);
    xfer_t r;
    r.c = 2'sd0;
    r.s = 2'sd0;
    case (pair_sum)
      3'sd2:  r.c = 2'sd1;
      -3'sd2: r.c = -2'sd1;
      3'sd1: begin
        if (low_nonneg) begin
          r.c = 2'sd1;
          r.s = -2'sd1;
        end else begin
          r.c = 2'sd0;
          r.s = 2'sd1;
        end
      end
      -3'sd1: begin
        if (low_nonneg) begin
          r.c = 2'sd0;
          r.s = -2'sd1;
        end else begin
          r.c = -2'sd1;
          r.s = 2'sd1;
        end
      end
      default: begin
        r.c = 2'sd0;
        r.s = 2'sd0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bsd_pair_sum.sv
module bsd_pair_sum
  import bsd_sd_pkg::*;
(
  input  logic              a_up,
  input  logic              a_dn,
  input  logic              b_up,
  input  logic              b_dn,
  output logic signed [2:0] pair_sum
);
  logic signed [1:0] va;
  logic signed [1:0] vb;

  assign va = dig_value(a_up, a_dn);
  assign vb = dig_value(b_up, b_dn);
  assign pair_sum = $signed({va[1], va}) + $signed({vb[1], vb});
endmodule

// File: rtl/bsd_xfer_cell.sv
module bsd_xfer_cell
  import bsd_sd_pkg::*;
(
  input  logic signed [2:0] pair_sum,
  input  logic              lo_a_up,
  input  logic              lo_a_dn,
  input  logic              lo_b_up,
  input  logic              lo_b_dn,
  output logic signed [1:0] xfer_c,
  output logic signed [1:0] xfer_s
);
  logic  low_nn;
  xfer_t pick;

  // Lower context: both digits one position down are >= 0.
  assign low_nn = dig_nonneg(lo_a_up, lo_a_dn) & dig_nonneg(lo_b_up, lo_b_dn);
  assign pick   = xfer_rule(pair_sum, low_nn);
  assign xfer_c = pick.c;
  assign xfer_s = pick.s;
endmodule

// File: rtl/bsd_merge_cell.sv
module bsd_merge_cell
  import bsd_sd_pkg::*;
(
  input  logic signed [1:0] rem_s,
  input  logic signed [1:0] carry_lo,
  output logic              z_up,
  output logic              z_dn
);
  logic signed [2:0] total;

  assign total        = $signed({rem_s[1], rem_s}) + $signed({carry_lo[1], carry_lo});
  assign {z_up, z_dn} = dig_encode(total);
endmodule

// File: rtl/bsd_cf_adder.sv
module bsd_cf_adder
  import bsd_sd_pkg::*;
#(
  parameter int unsigned DIGITS = 16
) (
  input  logic [DIGITS-1:0] a_pos,
  input  logic [DIGITS-1:0] a_neg,
  input  logic [DIGITS-1:0] b_pos,
  input  logic [DIGITS-1:0] b_neg,
  input  logic              cin_pos,
  input  logic              cin_neg,
  output logic [DIGITS:0]   sum_pos,
  output logic [DIGITS:0]   sum_neg
);
  localparam int unsigned RES_DIGITS = DIGITS + 1;

  // Named internal nets, observed by the bound checker.
  logic [DIGITS-1:0][2:0]     pair_sum;
  logic [DIGITS-1:0]          lo_a_up;
  logic [DIGITS-1:0]          lo_a_dn;
  logic [DIGITS-1:0]          lo_b_up;
  logic [DIGITS-1:0]          lo_b_dn;
  logic [DIGITS-1:0][1:0]     xfer_s;
  logic [RES_DIGITS-1:0][1:0] carry_v;   // carry_v[i]: transfer arriving at position i

  assign carry_v[0] = dig_value(cin_pos, cin_neg);

  for (genvar i = 0; i < DIGITS; i++) begin : g_pos
    if (i == 0) begin : g_low
      assign lo_a_up[i] = cin_pos;
      assign lo_a_dn[i] = cin_neg;
      assign lo_b_up[i] = 1'b0;
      assign lo_b_dn[i] = 1'b0;
    end else begin : g_mid
      assign lo_a_up[i] = a_pos[i-1];
      assign lo_a_dn[i] = a_neg[i-1];
      assign lo_b_up[i] = b_pos[i-1];
      assign lo_b_dn[i] = b_neg[i-1];
    end

    bsd_pair_sum u_sum (
      .a_up     (a_pos[i]),
      .a_dn     (a_neg[i]),
      .b_up     (b_pos[i]),
      .b_dn     (b_neg[i]),
      .pair_sum (pair_sum[i])
    );

    bsd_xfer_cell u_xfer (
      .pair_sum (pair_sum[i]),
      .lo_a_up  (lo_a_up[i]),
      .lo_a_dn  (lo_a_dn[i]),
      .lo_b_up  (lo_b_up[i]),
      .lo_b_dn  (lo_b_dn[i]),
      .xfer_c   (carry_v[i+1]),
      .xfer_s   (xfer_s[i])
    );

    bsd_merge_cell u_merge (
      .rem_s    (xfer_s[i]),
      .carry_lo (carry_v[i]),
      .z_up     (sum_pos[i]),
      .z_dn     (sum_neg[i])
    );
  end

  // Top result digit is the transfer leaving the top position.
  assign {sum_pos[DIGITS], sum_neg[DIGITS]} =
    dig_encode($signed({carry_v[DIGITS][1], carry_v[DIGITS]}));
endmodule

// File: rtl/bsd_cf_adder_chk.sv
module bsd_cf_adder_chk #(
  parameter int unsigned DIGITS = 16
) (
  input logic [DIGITS-1:0]      a_pos,
  input logic [DIGITS-1:0]      a_neg,
  input logic [DIGITS-1:0]      b_pos,
  input logic [DIGITS-1:0]      b_neg,
  input logic                   cin_pos,
  input logic                   cin_neg,
  input logic [DIGITS:0]        sum_pos,
  input logic [DIGITS:0]        sum_neg,
  input logic [DIGITS-1:0][1:0] xfer_s,
  input logic [DIGITS:0][1:0]   carry_v
);
  always_comb begin : chk
    int op_val;
    int res_val;
    int loc;
    int cy;
    bit known;
    known = !$isunknown({a_pos, a_neg, b_pos, b_neg, cin_pos, cin_neg});
    op_val  = int'(cin_pos) - int'(cin_neg);
    res_val = 0;
    for (int i = 0; i < int'(DIGITS); i++) begin
      op_val += (int'(a_pos[i]) - int'(a_neg[i]) + int'(b_pos[i]) - int'(b_neg[i])) * (1 << i);
    end
    for (int i = 0; i <= int'(DIGITS); i++) begin
      res_val += (int'(sum_pos[i]) - int'(sum_neg[i])) * (1 << i);
    end
    if (known) begin
      p_word_value_r1: assert (res_val == op_val)
        else $error("R1 result value %0d differs from operand total %0d", res_val, op_val);
      p_canonical_r3: assert ((sum_pos & sum_neg) == '0)
        else $error("R3 result digit driven as 1/1");
      for (int i = 0; i < int'(DIGITS); i++) begin
        loc = int'($signed(xfer_s[i]));
        cy  = int'($signed(carry_v[i]));
        p_no_overflow_r5: assert (loc + cy >= -1 && loc + cy <= 1)
          else $error("R5 position %0d remainder %0d plus transfer %0d leaves digit range", i, loc, cy);
        // R5: a pair with no negative digit never sends a negative transfer, and vice versa.
        p_xfer_sign_r5: assert (
            !(( a_neg[i] & ~a_pos[i]) == 1'b0 && (b_neg[i] & ~b_pos[i]) == 1'b0 &&
              $signed(carry_v[i+1]) < 0) &&
            !(( a_pos[i] & ~a_neg[i]) == 1'b0 && (b_pos[i] & ~b_neg[i]) == 1'b0 &&
              $signed(carry_v[i+1]) > 0))
          else $error("R5 position %0d transfer sign disagrees with its digit pair", i);
      end
    end
  end
endmodule

bind bsd_cf_adder bsd_cf_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .a_pos   (a_pos),
  .a_neg   (a_neg),
  .b_pos   (b_pos),
  .b_neg   (b_neg),
  .cin_pos (cin_pos),
  .cin_neg (cin_neg),
  .sum_pos (sum_pos),
  .sum_neg (sum_neg),
  .xfer_s  (xfer_s),
  .carry_v (carry_v)
);

// File: tb/bsd_cf_adder_test.sv
module bsd_cf_adder_test;
  localparam int N  = 16;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [N-1:0] a_p = '0, a_n = '0, b_p = '0, b_n = '0;
  logic         c_p = 1'b0, c_n = 1'b0;
  logic [N:0]   z_p, z_n;

  logic [NS-1:0] sa_p = '0, sa_n = '0, sb_p = '0, sb_n = '0;
  logic          sc_p = 1'b0, sc_n = 1'b0;
  logic [NS:0]   sz_p, sz_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bsd_cf_adder #(.DIGITS(N)) uut (
    .a_pos(a_p), .a_neg(a_n), .b_pos(b_p), .b_neg(b_n),
    .cin_pos(c_p), .cin_neg(c_n), .sum_pos(z_p), .sum_neg(z_n));

  bsd_cf_adder #(.DIGITS(NS)) uut_small (
    .a_pos(sa_p), .a_neg(sa_n), .b_pos(sb_p), .b_neg(sb_n),
    .cin_pos(sc_p), .cin_neg(sc_n), .sum_pos(sz_p), .sum_neg(sz_n));

  // Word value as integer: digit i weighs 2^i, digit = up - down.
  function automatic int rail_value(input logic [31:0] p, input logic [31:0] n, input int w);
    int v = 0;
    for (int i = w - 1; i >= 0; i--) v = v * 2 + (int'(p[i]) - int'(n[i]));
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic drive(input logic [N-1:0] ap, an, bp, bn, input logic cp, cn);
    @(posedge clk);
    a_p = ap; a_n = an; b_p = bp; b_n = bn; c_p = cp; c_n = cn;
    settle();
  endtask

  task automatic rand_word(output logic [N-1:0] p, output logic [N-1:0] n);
    for (int i = 0; i < N; i++) begin
      logic [1:0] code;
      code = 2'($urandom_range(0, 3));
      p[i] = code[1];
      n[i] = code[0];
    end
  endtask

  task automatic check_value(input string req);
    int exp_v = rail_value(a_p, a_n, N) + rail_value(b_p, b_n, N) + (int'(c_p) - int'(c_n));
    int act_v = rail_value(z_p, z_n, N + 1);
    check(act_v == exp_v, req, "word value", act_v, exp_v);
    check((z_p & z_n) == '0, "R3", "no 1/1 result digit", int'(z_p & z_n), 0);
  endtask

  // Expected result digits given as an integer per position; rest zero.
  task automatic check_digits(input string req, input int lo_pos, input int d0, d1, d2);
    logic [N:0] ep = '0, en = '0;
    int dv[3];
    dv = '{d0, d1, d2};
    for (int j = 0; j < 3; j++) begin
      if (lo_pos + j <= N && lo_pos + j >= 0) begin
        ep[lo_pos + j] = (dv[j] == 1);
        en[lo_pos + j] = (dv[j] == -1);
      end
    end
    check(z_p == ep && z_n == en, req, "digit pattern",
          rail_value(z_p, z_n, N + 1), rail_value(ep, en, N + 1));
  endtask

  // One R5 scenario at position k with lower pair at k-1, all else zero.
  task automatic r5_case(input int k, input int ak, bk, alo, blo, input int e_lo, e_k, e_hi);
    logic [N-1:0] ap = '0, an = '0, bp = '0, bn = '0;
    ap[k] = (ak == 1);  an[k] = (ak == -1);
    bp[k] = (bk == 1);  bn[k] = (bk == -1);
    ap[k-1] = (alo == 1); an[k-1] = (alo == -1);
    bp[k-1] = (blo == 1); bn[k-1] = (blo == -1);
    drive(ap, an, bp, bn, 1'b0, 1'b0);
    check_digits("R5", k - 1, e_lo, e_k, e_hi);
    check_value("R1");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] ap, an, bp, bn;
    logic [N:0]   keep_p, keep_n;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    settle();
    // Reset state: idle zero inputs give canonical all-zero output (R3).
    check(z_p == '0 && z_n == '0, "R3", "idle output zero", rail_value(z_p, z_n, N + 1), 0);

    // R5 transfer rule at position 3.
    r5_case(3,  1,  1,  0, 0,  0,  0,  1);
    r5_case(3, -1, -1,  0, 0,  0,  0, -1);
    r5_case(3,  1, -1,  0, 0,  0,  0,  0);
    r5_case(3,  1,  0,  0, 0,  0, -1,  1);
    r5_case(3,  1,  0, -1, 0, -1,  1,  0);
    r5_case(3, -1,  0,  0, 0,  0, -1,  0);
    r5_case(3, -1,  0, -1, 0, -1,  1, -1);
    r5_case(3,  0,  1,  1, 0, -1,  0,  1);

    // R6 carry-in and top digit.
    drive('0, '0, '0, '0, 1'b1, 1'b0);
    check_digits("R6", 0, 1, 0, 0);
    drive('0, '0, '0, '0, 1'b0, 1'b1);
    check_digits("R6", 0, -1, 0, 0);
    drive('0, '0, '0, '0, 1'b1, 1'b1);
    check_digits("R2", 0, 0, 0, 0);
    drive('1, '0, '1, '0, 1'b0, 1'b0);
    check(z_p == {{N{1'b1}}, 1'b0} && z_n == '0, "R6", "all +1 operands",
          rail_value(z_p, z_n, N + 1), 2 * ((1 << N) - 1));
    drive('0, '1, '0, '1, 1'b0, 1'b1);
    check(z_p == '0 && z_n == '1, "R6", "all -1 operands with -1 carry-in",
          rail_value(z_p, z_n, N + 1), -((1 << (N + 1)) - 1));
    check(z_n[N] == 1'b1, "R6", "top digit is outgoing transfer", int'(z_n[N]), 1);

    // R1 random operands, every encoding including 1/1.
    for (int t = 0; t < 3000; t++) begin
      logic [1:0] cc;
      rand_word(ap, an);
      rand_word(bp, bn);
      cc = 2'($urandom_range(0, 3));
      drive(ap, an, bp, bn, cc[1], cc[0]);
      check_value("R1");
    end

    // R2: redundant zero 1/1 instead of 0/0 changes nothing.
    for (int t = 0; t < 300; t++) begin
      logic [1:0] cc;
      logic [N-1:0] za, zb;
      rand_word(ap, an);
      rand_word(bp, bn);
      cc = 2'($urandom_range(0, 3));
      if (cc == 2'b11) cc = 2'b00;
      drive(ap, an, bp, bn, cc[1], cc[0]);
      keep_p = z_p; keep_n = z_n;
      za = ~(ap | an);
      zb = ~(bp | bn);
      drive(ap | za, an | za, bp | zb, bn | zb, cc[1] | (cc == 2'b00), cc[0] | (cc == 2'b00));
      check(z_p == keep_p && z_n == keep_n, "R2", "rails after 1/1 zero",
            rail_value(z_p, z_n, N + 1), rail_value(keep_p, keep_n, N + 1));
    end

    // R4: upper operand digits leave lower result digits alone.
    for (int t = 0; t < 300; t++) begin
      int k;
      logic [N-1:0] np, nn, mp, mn, hi;
      logic [N:0] msk;
      logic [1:0] cc;
      k = $urandom_range(1, N - 1);
      rand_word(ap, an);
      rand_word(bp, bn);
      cc = 2'($urandom_range(0, 3));
      drive(ap, an, bp, bn, cc[1], cc[0]);
      keep_p = z_p; keep_n = z_n;
      hi  = ~((N'(1) << k) - N'(1));
      msk = (N+1)'((N'(1) << k) - N'(1));
      rand_word(np, nn);
      rand_word(mp, mn);
      drive((ap & ~hi) | (np & hi), (an & ~hi) | (nn & hi),
            (bp & ~hi) | (mp & hi), (bn & ~hi) | (mn & hi), cc[1], cc[0]);
      check((z_p & msk) == (keep_p & msk) && (z_n & msk) == (keep_n & msk), "R4",
            "low result digits after upper change",
            rail_value(z_p & msk, z_n & msk, N + 1), rail_value(keep_p & msk, keep_n & msk, N + 1));
    end

    // Exhaustive two-digit width: all codes on every input rail pair.
    for (int ac = 0; ac < 16; ac++) begin
      for (int bc = 0; bc < 16; bc++) begin
        for (int cc = 0; cc < 4; cc++) begin
          int ev, av;
          @(posedge clk);
          sa_p = {ac[3], ac[1]}; sa_n = {ac[2], ac[0]};
          sb_p = {bc[3], bc[1]}; sb_n = {bc[2], bc[0]};
          sc_p = cc[1];          sc_n = cc[0];
          settle();
          ev = rail_value(sa_p, sa_n, NS) + rail_value(sb_p, sb_n, NS) + (int'(sc_p) - int'(sc_n));
          av = rail_value(sz_p, sz_n, NS + 1);
          check(av == ev, "R1", "two-digit exhaustive value", av, ev);
          check((sz_p & sz_n) == '0, "R3", "two-digit canonical", int'(sz_p & sz_n), 0);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule